// File: doc/BRIEF.md
# Static RAM Bus Memory Controller

This controller connects a 32-bit synchronous processor bus to a 32-bit static RAM that is built from four byte-wide banks working in parallel. When the bus address strobe is sampled high, the controller checks whether the address is inside the RAM window, which is the lowest 2^15 words. A miss is dropped without any response. A hit starts a fixed strobe sequence: chip select first, then the write strobe for writes, then the write strobe released while chip select is still held, and finally a one-clock ready pulse back to the bus.

The access phase can be stretched by a wait-state count that is fixed when the block is built. Slow RAM parts are handled by raising that count. Address and write data are latched when the cycle is accepted and stay constant until chip select drops, so the RAM sees stable inputs on both sides of the write strobe. Read data is captured in a register on the last chip-select clock and is valid while ready is high.

Top module: `sram_bus_ctrl`

## Requirements
- R1: A bus strobe is accepted only when bus_addr[31:15] are all zero, which covers word addresses 0 to 32767.
- R2: A strobe with any of bus_addr[31:15] set produces no chip select, no write strobe and no ready, and it changes no stored word.
- R3: mem_addr equals bus_addr[14:0] of the accepted cycle and stays unchanged for every clock in which chip select is high.
- R4: Bank b (b = 0..3) stores mem_wdata bits [31-8b:24-8b], so bank 0 holds bus bits 31..24 and bank 3 holds bits 7..0.
- R5: Chip select rises one clock before the write strobe and falls one clock after it. The write strobe is never high without chip select, and it stays low for the whole of a read.
- R6: With WAIT_N wait states, chip select is high for WAIT_N+3 clocks and the write strobe is high for WAIT_N+1 clocks on a write.
- R7: Ready is high for exactly one clock. It rises on the (WAIT_N+3)th rising edge after the edge that sampled the strobe, and chip select falls on that same edge.
- R8: On a read, bus_rdata equals the addressed 32-bit word while ready is high, and it holds that value until the next read completes.
- R9: A strobe that arrives while a cycle is in progress, including the ready clock itself, is ignored.
- R10: After reset, chip select, write strobe and ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_as | input | 1 | Address strobe, one clock per cycle |
| bus_wr | input | 1 | 1 for write, 0 for read, sampled with the strobe |
| bus_addr | input | 32 | Bus word address |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rdy | output | 1 | One-clock completion pulse |
| mem_addr | output | 15 | Address to all four banks |
| mem_wdata | output | 32 | Write data, split into byte lanes across the banks |
| mem_rdata | input | 32 | Read data gathered from the four banks |
| bank_cs | output | 4 | Per-bank chip select, active high |
| bank_we | output | 4 | Per-bank write strobe, active high |

## Verification
The bench writes a distinct arithmetic pattern to every word in a block of low addresses and to the top word of the window, then reads each one back. This exercises the lane mapping and the read path, and a wrong data or address bit shows up as a mismatched word. For every transaction it counts the chip-select, write-strobe and ready clocks and measures the ready latency, which separates reads from writes and confirms the wait count. Out-of-window strobes whose low bits alias words that were already written check that a miss leaves the RAM untouched. Strobes injected during the access phase and during the ready clock confirm that a busy controller ignores them.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACCESS,
    ST_HOLD,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/sram_addr_decode.sv
module sram_addr_decode #(
  parameter int ADDR_W = 32,
  parameter int MEM_AW = 15
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  // the window is the lowest 2^MEM_AW words; any high bit set is a miss
  assign hit = ~|addr[ADDR_W-1:MEM_AW];
endmodule

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int WAIT_N = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int CW = (WAIT_N > 0) ? $clog2(WAIT_N + 1) : 1;
  localparam logic [CW-1:0] LOAD_V = CW'(WAIT_N);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= LOAD_V;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

  // R6: the remaining wait count never exceeds the configured wait states
  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt <= LOAD_V);
endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
  import sram_ctrl_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bus_as,
  input  logic hit,
  input  logic wr_q,
  input  logic timer_exp,
  output logic accept,
  output logic timer_load,
  output logic timer_run,
  output logic capture,
  output logic cs,
  output logic we,
  output logic rdy
);
  seq_state_t state;

  assign accept     = (state == ST_IDLE) && bus_as && hit;
  assign timer_load = (state == ST_SETUP);
  assign timer_run  = (state == ST_ACCESS);
  assign capture    = (state == ST_HOLD) && !wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cs    <= 1'b0;
      we    <= 1'b0;
      rdy   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            cs    <= 1'b1;
            state <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          we    <= wr_q;
          state <= ST_ACCESS;
        end
        ST_ACCESS: begin
          if (timer_exp) begin
            we    <= 1'b0;
            state <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          cs    <= 1'b0;
          rdy   <= 1'b1;
          state <= ST_DONE;
        end
        ST_DONE: begin
          rdy   <= 1'b0;
          state <= ST_IDLE;
        end
        default: begin
          cs    <= 1'b0;
          we    <= 1'b0;
          rdy   <= 1'b0;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // R5: the write strobe lives strictly inside chip select
  assert_we_inside_cs_R5: assert property (@(posedge clk) disable iff (rst)
    we |-> cs);
  assert_we_lead_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(we) |-> $past(cs));
  assert_cs_tail_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(we) |-> cs);
  // R7: ready is a single clock and coincides with chip select dropping
  assert_rdy_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);
  assert_rdy_after_cs_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy) |-> (!cs && $past(cs)));
  // R2: a miss seen while idle starts nothing
  assert_miss_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && bus_as && !hit) |=> !cs);
endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int MEM_AW = 15,
  parameter int WAIT_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_as,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdy,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W/LANE_W-1:0] bank_cs,
  output logic [DATA_W/LANE_W-1:0] bank_we
);
  localparam int NB = DATA_W / LANE_W;

  logic hit, accept, timer_load, timer_run, timer_exp, capture;
  logic cs, we, wr_q;

  sram_addr_decode #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_dec (
    .addr (bus_addr),
    .hit  (hit)
  );

  sram_wait_timer #(.WAIT_N(WAIT_N)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (timer_load),
    .run     (timer_run),
    .expired (timer_exp)
  );

  sram_strobe_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .bus_as     (bus_as),
    .hit        (hit),
    .wr_q       (wr_q),
    .timer_exp  (timer_exp),
    .accept     (accept),
    .timer_load (timer_load),
    .timer_run  (timer_run),
    .capture    (capture),
    .cs         (cs),
    .we         (we),
    .rdy        (bus_rdy)
  );

  // cycle attributes are frozen at accept and held through the strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      wr_q      <= 1'b0;
    end else if (accept) begin
      mem_addr  <= bus_addr[MEM_AW-1:0];
      mem_wdata <= bus_wdata;
      wr_q      <= bus_wr;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (capture) begin
      bus_rdata <= mem_rdata;
    end
  end

  // every byte bank shares the same strobes; lanes differ only in data slice
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bank_cs[b] = cs;
    assign bank_we[b] = we;
  end

  // R3: the RAM address cannot move while chip select is held
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (cs && $past(cs)) |-> $stable(mem_addr));
  // R3: write data is also frozen across the strobe window
  assert_wdata_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (cs && $past(cs)) |-> $stable(mem_wdata));
endmodule

// File: tb/sram_bus_ctrl_test.sv
`timescale 1ns/1ps
module sram_bus_ctrl_test;
  localparam int WAIT_N = 2;
  localparam int DEPTH  = 512;
  localparam int WIN    = 2 * WAIT_N + 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_as = 1'b0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rdy;
  logic [14:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic [3:0]  bank_cs, bank_we;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sram_bus_ctrl #(.WAIT_N(WAIT_N)) uut (
    .clk(clk), .rst(rst), .bus_as(bus_as), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdy(bus_rdy), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .bank_cs(bank_cs), .bank_we(bank_we)
  );

  // behavioural byte banks, shallow: indexed by low address bits
  logic [7:0] bank_mem [4][DEPTH];
  wire  [8:0] idx = mem_addr[8:0];

  always @(posedge clk)
    for (int b = 0; b < 4; b++)
      if (bank_cs[b] && bank_we[b]) bank_mem[b][idx] <= mem_wdata[8*(3-b) +: 8];

  assign mem_rdata = {bank_mem[0][idx], bank_mem[1][idx], bank_mem[2][idx], bank_mem[3][idx]};

  function automatic logic [31:0] pat(input logic [31:0] a);
    return (a + 32'd1) * 32'h9E37_79B9 ^ 32'h0F0F_3355;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic txn(input logic wr, input logic [31:0] addr, input logic [31:0] data,
                     input logic intrude, output logic [31:0] rd);
    int lat = 0, ncs = 0, nwe = 0, nrdy = 0, unstable = 0;
    logic [14:0] a0 = '0;
    logic hit = (addr[31:15] == 17'd0);
    rd = 'x;
    @(negedge clk);
    bus_as = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    bus_as = 1'b0;
    for (int s = 1; s <= WIN; s++) begin
      if (bank_cs[0]) begin
        if (ncs == 0) a0 = mem_addr;
        else if (mem_addr !== a0) unstable++;
        ncs++;
      end
      if (bank_we[0]) nwe++;
      if (bus_rdy) begin
        nrdy++;
        if (lat == 0) begin lat = s; rd = bus_rdata; end
      end
      bus_as = 1'b0;
      if (intrude && (s == 2 || s == WAIT_N + 4)) begin
        // R9: strobe during access phase and during the ready clock
        bus_as = 1'b1; bus_wr = 1'b1; bus_addr = 32'd7; bus_wdata = 32'hDEAD_BEEF;
      end
      @(negedge clk);
    end
    bus_as = 1'b0;
    if (hit) begin
      chk("R7 ready latency", lat, WAIT_N + 4);
      chk("R7 ready width", nrdy, 1);
      chk("R6 cs clocks", ncs, WAIT_N + 3);
      chk("R5/R6 we clocks", nwe, wr ? WAIT_N + 1 : 0);
      chk("R3 address value", {17'd0, a0}, {17'd0, addr[14:0]});
      chk("R3 address stable", unstable, 0);
    end else begin
      chk("R2 miss cs", ncs, 0);
      chk("R2 miss we", nwe, 0);
      chk("R2 miss rdy", nrdy, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 cs", {31'd0, bank_cs[0]}, 0);
    chk("R10 we", {31'd0, bank_we[0]}, 0);
    chk("R10 rdy", {31'd0, bus_rdy}, 0);
    rst = 1'b0;

    // R1/R6: sweep writes over low words plus the window edges
    for (int a = 0; a < 32; a++) txn(1'b1, a, pat(a), 1'b0, rd);
    txn(1'b1, 32'd32767, pat(32767), 1'b0, rd);
    txn(1'b1, 32'd20000, 32'h1122_3344, 1'b0, rd);

    // R4: lane split into the banks
    chk("R4 bank0 lane", {24'd0, bank_mem[0][20000 % DEPTH]}, 32'h11);
    chk("R4 bank1 lane", {24'd0, bank_mem[1][20000 % DEPTH]}, 32'h22);
    chk("R4 bank2 lane", {24'd0, bank_mem[2][20000 % DEPTH]}, 32'h33);
    chk("R4 bank3 lane", {24'd0, bank_mem[3][20000 % DEPTH]}, 32'h44);

    // R8: read back everything
    for (int a = 0; a < 32; a++) begin
      txn(1'b0, a, 32'd0, 1'b0, rd);
      chk("R8 read data", rd, pat(a));
    end
    txn(1'b0, 32'd32767, 32'd0, 1'b0, rd);
    chk("R8 read top word", rd, pat(32767));
    chk("R8 read data held", bus_rdata, pat(32767));

    // R2: misses whose low bits alias written words
    txn(1'b1, 32'h0000_8005, 32'hBAD0_0001, 1'b0, rd);
    txn(1'b1, 32'hFFFF_0003, 32'hBAD0_0002, 1'b0, rd);
    txn(1'b0, 32'h8000_0009, 32'd0, 1'b0, rd);
    chk("R8 rdata unchanged by miss", bus_rdata, pat(32767));
    txn(1'b0, 32'd5, 32'd0, 1'b0, rd);
    chk("R2 alias word 5 untouched", rd, pat(5));
    txn(1'b0, 32'd3, 32'd0, 1'b0, rd);
    chk("R2 alias word 3 untouched", rd, pat(3));

    // R9: strobes while busy are dropped
    txn(1'b1, 32'd12, 32'hC0DE_0012, 1'b1, rd);
    txn(1'b0, 32'd7, 32'd0, 1'b0, rd);
    chk("R9 busy strobe ignored", rd, pat(7));
    txn(1'b0, 32'd12, 32'd0, 1'b1, rd);
    chk("R9 read during intrusion", rd, 32'hC0DE_0012);
    txn(1'b0, 32'd7, 32'd0, 1'b0, rd);
    chk("R9 word 7 still intact", rd, pat(7));

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule